// File: doc/BRIEF.md
# Tuner Command Byte Parser

This block sits behind a serial byte link and turns a stream of fixed-length command frames into tuner settings. Each frame is one opcode byte followed by a 32-bit argument sent most significant byte first. The block keeps three registers on its outputs: the local-oscillator frequency, the sample rate and a linear gain code. Opcodes retune the oscillator, change the sample rate, set the gain in tenths of a decibel, or pick the gain from a fixed list of steps.

The parser also tracks a streaming state. The first complete frame that arrives while idle starts a stream. The block then pulses a start strobe and sends a fixed 12-byte announcement on its header output, one byte per cycle. During that time it refuses input. A single zero byte that arrives where a new frame would begin ends the stream. Decibel values become linear gain through a table that is computed at elaboration and rounded to the nearest integer.

Top module: `tuner_cmd_parser`

## Requirements
- R1: A frame is an opcode byte followed by four argument bytes, most significant first. A byte is accepted on a clock edge where in_valid and in_ready are both high. The registers take their new values in the cycle after the fifth byte is accepted. Idle cycles between bytes do not disturb the framing.
- R2: A zero byte accepted when no frame is pending is never stored as an opcode. While streaming it raises stop_pulse for one cycle and clears streaming. While idle it has no effect. A zero byte in positions 1 to 4 is ordinary argument data.
- R3: Opcode 0x01 sets lo_freq to the argument plus the current samp_rate, modulo 2^32.
- R4: Opcode 0x02 sets samp_rate to the argument and sets lo_freq to the argument plus the new rate, which is twice the argument modulo 2^32.
- R5: Opcode 0x04 sets gain_code to round(127 × 10^(t/200)). Here t is the argument, limited to at most 511.
- R6: Opcode 0x0D limits its argument to at most 28 and uses it as an index into the step list, in tenths of a dB: 0, 9, 14, 27, 37, 77, 87, 125, 144, 157, 166, 197, 207, 229, 254, 280, 297, 328, 338, 364, 372, 386, 402, 421, 434, 439, 445, 480, 496. gain_code becomes round(127 × 10^(step/200)).
- R7: A complete frame with any opcode that ends while idle does three things. It raises start_pulse for one cycle and sets streaming. Starting in that same cycle, it drives hdr_valid for 12 consecutive cycles carrying the bytes 52 54 4C 30 00 00 00 05 00 00 00 1D in that order. in_ready is low while hdr_valid is high.
- R8: Frames that end while streaming update the registers but raise neither start_pulse nor a header.
- R9: A frame with any other nonzero opcode leaves lo_freq, samp_rate and gain_code unchanged.
- R10: After reset: samp_rate = 100000, lo_freq = 94500000, gain_code = 127, streaming = 0, in_ready = 1, hdr_valid = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Block can take a byte |
| hdr_valid | output | 1 | Header byte present |
| hdr_data | output | 8 | Header byte |
| lo_freq | output | 32 | Oscillator frequency in Hz |
| samp_rate | output | 32 | Sample rate in Hz |
| gain_code | output | 16 | Linear gain |
| streaming | output | 1 | Stream is active |
| start_pulse | output | 1 | One-cycle strobe when a stream starts |
| stop_pulse | output | 1 | One-cycle strobe when a stream stops |

## Verification
The bench builds the block with its default parameters. That means a 32-bit argument, a 16-bit gain code and a decibel table reaching 511 tenths. With these values the full 12-byte header can be observed, the step index can be pushed past its last entry, and the decibel argument can be pushed beyond the table so that the gain saturates at its largest entry. The 32-bit width also lets the oscillator sum wrap around. The bench works out each expected gain from the power formula on its own.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
   localparam logic [7:0] OP_TUNE = 8'h01;
   localparam logic [7:0] OP_RATE = 8'h02;
   localparam logic [7:0] OP_GDB  = 8'h04;
   localparam logic [7:0] OP_GIDX = 8'h0D;

   localparam int unsigned STEP_N    = 29;
   localparam int unsigned STEP_LAST = STEP_N - 1;
   localparam int unsigned STEP_TOP  = 496;

   function automatic int unsigned step_tdb(input int unsigned idx);
      case (idx)
         0: return 0;     1: return 9;     2: return 14;    3: return 27;
         4: return 37;    5: return 77;    6: return 87;    7: return 125;
         8: return 144;   9: return 157;  10: return 166;  11: return 197;
        12: return 207;  13: return 229;  14: return 254;  15: return 280;
        16: return 297;  17: return 328;  18: return 338;  19: return 364;
        20: return 372;  21: return 386;  22: return 402;  23: return 421;
        24: return 434;  25: return 439;  26: return 445;  27: return 480;
        default: return 496;
      endcase
   endfunction

   function automatic int unsigned lin_gain(input int unsigned tdb, input int unsigned base);
      real v;
      v = real'(base) * (10.0 ** (real'(tdb) / 200.0));
      return $rtoi(v + 0.5);
   endfunction
endpackage

// File: rtl/tcp_frame_asm.sv
module tcp_frame_asm #(
   parameter int ARG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic [7:0]       in_data,
   output logic             frame_done,
   output logic             brk,
   output logic [7:0]       op,
   output logic [ARG_W-1:0] arg
);
   localparam int NB = ARG_W / 8;
   localparam int FL = NB + 1;
   localparam int PW = $clog2(FL + 1);
   localparam logic [PW-1:0] LAST = PW'(FL - 1);

   generate
      if (ARG_W % 8 != 0 || NB < 2) begin : g_bad_w
         $error("ARG_W must be a multiple of 8 and at least 16");
      end
   endgenerate

   logic [PW-1:0]      pos;
   logic [7:0]         op_q;
   logic [ARG_W-9:0]   arg_q;

   assign brk        = acc && (pos == '0) && (in_data == 8'h00);
   assign frame_done = acc && (pos == LAST);
   assign op         = op_q;
   assign arg        = {arg_q, in_data};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos   <= '0;
         op_q  <= '0;
         arg_q <= '0;
      end else if (acc && !brk) begin
         if (pos == '0) op_q <= in_data;
         else           arg_q <= (ARG_W-8)'({arg_q, in_data});
         pos <= frame_done ? '0 : pos + 1'b1;
      end
   end

   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= LAST);                                             // R1
   AST_BREAK_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> (pos == '0));                                     // R2
   AST_FRAME_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (pos == '0));                              // R1
endmodule

// File: rtl/tcp_gain_rom.sv
module tcp_gain_rom #(
   parameter int GAIN_W  = 16,
   parameter int TDB_MAX = 511,
   parameter int BASE    = 127,
   localparam int TDB_W  = $clog2(TDB_MAX + 1)
) (
   input  logic [TDB_W-1:0]  tdb,
   output logic [GAIN_W-1:0] gain
);
   localparam int DEPTH = TDB_MAX + 1;

   generate
      if (tcp_pkg::lin_gain(TDB_MAX, BASE) >= (64'd1 << GAIN_W)) begin : g_bad_gw
         $error("GAIN_W too narrow for the largest table entry");
      end
      if (TDB_MAX < int'(tcp_pkg::STEP_TOP)) begin : g_bad_max
         $error("TDB_MAX must cover the step list");
      end
   endgenerate

   logic [GAIN_W-1:0] rom [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_rom
      assign rom[g] = GAIN_W'(tcp_pkg::lin_gain(g, BASE));
   end

   always_comb begin
      gain = rom[0];
      if (int'(tdb) < DEPTH) gain = rom[tdb];
   end
endmodule

// File: rtl/tcp_hdr_emit.sv
module tcp_hdr_emit #(
   parameter logic [31:0] MAGIC = 32'h5254_4C30,
   parameter logic [31:0] KIND  = 32'd5,
   parameter logic [31:0] STEPS = 32'd29
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   output logic       valid,
   output logic [7:0] data
);
   localparam int NBYTES = 12;
   localparam int IW     = $clog2(NBYTES);
   localparam logic [8*NBYTES-1:0] IMG = {MAGIC, KIND, STEPS};
   localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

   logic [IW-1:0] idx;

   assign data = valid ? IMG[8*NBYTES-1 - 8*idx -: 8] : 8'h00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         idx   <= '0;
      end else if (go && !valid) begin
         valid <= 1'b1;
         idx   <= '0;
      end else if (valid) begin
         if (idx == LAST) valid <= 1'b0;
         idx <= (idx == LAST) ? '0 : idx + 1'b1;
      end
   end

   AST_HDR_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && idx != LAST) |=> valid);                       // R7
   AST_HDR_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> (idx == '0));                           // R7
endmodule

// File: rtl/tuner_cmd_parser.sv
module tuner_cmd_parser #(
   parameter int ARG_W       = 32,
   parameter int GAIN_W      = 16,
   parameter int TDB_MAX     = 511,
   parameter int GAIN_BASE   = 127,
   parameter int INIT_RATE   = 100000,
   parameter int INIT_CENTER = 94600000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic              hdr_valid,
   output logic [7:0]        hdr_data,
   output logic [ARG_W-1:0]  lo_freq,
   output logic [ARG_W-1:0]  samp_rate,
   output logic [GAIN_W-1:0] gain_code,
   output logic              streaming,
   output logic              start_pulse,
   output logic              stop_pulse
);
   import tcp_pkg::*;

   localparam int TDB_W = $clog2(TDB_MAX + 1);
   localparam logic [ARG_W-1:0] RATE0 = ARG_W'(INIT_RATE);
   localparam logic [ARG_W-1:0] LO0   = ARG_W'(INIT_CENTER - INIT_RATE);
   localparam logic [GAIN_W-1:0] GAIN0 = GAIN_W'(GAIN_BASE);

   generate
      if (INIT_CENTER < INIT_RATE) begin : g_bad_init
         $error("INIT_CENTER must not be below INIT_RATE");
      end
   endgenerate

   logic             acc, frame_done, brk;
   logic [7:0]       op;
   logic [ARG_W-1:0] arg;
   logic [TDB_W-1:0] tdb_sel;
   logic [GAIN_W-1:0] rom_gain;
   logic             hdr_go;

   assign in_ready = !hdr_valid;
   assign acc      = in_valid && in_ready;

   tcp_frame_asm #(.ARG_W(ARG_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .acc(acc), .in_data(in_data),
      .frame_done(frame_done), .brk(brk), .op(op), .arg(arg)
   );

   always_comb begin
      int unsigned idx;
      idx = (arg > ARG_W'(STEP_LAST)) ? STEP_LAST : int'(arg);
      if (op == OP_GIDX)
         tdb_sel = TDB_W'(step_tdb(idx));
      else if (arg > ARG_W'(TDB_MAX))
         tdb_sel = TDB_W'(TDB_MAX);
      else
         tdb_sel = arg[TDB_W-1:0];
   end

   tcp_gain_rom #(.GAIN_W(GAIN_W), .TDB_MAX(TDB_MAX), .BASE(GAIN_BASE)) u_rom (
      .tdb(tdb_sel), .gain(rom_gain)
   );

   assign hdr_go = frame_done && !streaming;

   tcp_hdr_emit #(.STEPS(32'(STEP_N))) u_hdr (
      .clk(clk), .rst_n(rst_n), .go(hdr_go), .valid(hdr_valid), .data(hdr_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_freq     <= LO0;
         samp_rate   <= RATE0;
         gain_code   <= GAIN0;
         streaming   <= 1'b0;
         start_pulse <= 1'b0;
         stop_pulse  <= 1'b0;
      end else begin
         start_pulse <= hdr_go;
         stop_pulse  <= brk && streaming;
         if (hdr_go)                streaming <= 1'b1;
         else if (brk && streaming) streaming <= 1'b0;
         if (frame_done) begin
            case (op)
               OP_TUNE: lo_freq <= arg + samp_rate;
               OP_RATE: begin
                  samp_rate <= arg;
                  lo_freq   <= arg + arg;
               end
               OP_GDB, OP_GIDX: gain_code <= rom_gain;
               default: ;
            endcase
         end
      end
   end

   AST_HDR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> !in_ready);                                 // R7
   AST_START_WITH_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(streaming) |-> (start_pulse && hdr_valid));         // R7
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> (!streaming && $past(streaming)));         // R2
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_pulse, stop_pulse}));                     // R8
   AST_RATE_RETUNES: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_rate != $past(samp_rate)) |-> (lo_freq == samp_rate + samp_rate)); // R4
endmodule

// File: tb/tb_tuner_cmd_parser.sv
module tb_tuner_cmd_parser;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready, hdr_valid, streaming, start_pulse, stop_pulse;
   logic [7:0]  hdr_data;
   logic [31:0] lo_freq, samp_rate;
   logic [15:0] gain_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tuner_cmd_parser dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
      .lo_freq(lo_freq), .samp_rate(samp_rate), .gain_code(gain_code),
      .streaming(streaming), .start_pulse(start_pulse), .stop_pulse(stop_pulse)
   );

   function automatic int unsigned ref_gain(input int unsigned t);
      real v;
      v = 127.0 * (10.0 ** (real'(t) / 200.0));
      return $rtoi(v + 0.5);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input int gap);
      logic rdy;
      repeat (gap) @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      do begin
         rdy = in_ready;
         @(negedge clk);
      end while (!rdy);
      in_valid = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] op, input logic [31:0] arg, input int gap);
      send_byte(op, gap);
      for (int i = 3; i >= 0; i--) send_byte(arg[8*i +: 8], gap);
   endtask

   task automatic check_header(input string req);
      logic [7:0] exp_hdr [12];
      exp_hdr = '{8'h52, 8'h54, 8'h4C, 8'h30, 8'h00, 8'h00, 8'h00, 8'h05,
                  8'h00, 8'h00, 8'h00, 8'h1D};
      chk({req, " start_pulse"}, 32'(start_pulse), 1);
      chk({req, " in_ready low"}, 32'(in_ready), 0);
      for (int i = 0; i < 12; i++) begin
         chk({req, " hdr_valid"}, 32'(hdr_valid), 1);
         chk({req, " hdr_data"}, 32'(hdr_data), 32'(exp_hdr[i]));
         @(negedge clk);
      end
      chk({req, " hdr end"}, 32'(hdr_valid), 0);
      chk({req, " in_ready back"}, 32'(in_ready), 1);
   endtask

   task automatic t_reset;
      chk("R10 rate", samp_rate, 32'd100000);
      chk("R10 lo", lo_freq, 32'd94500000);
      chk("R10 gain", 32'(gain_code), 32'd127);
      chk("R10 streaming", 32'(streaming), 0);
      chk("R10 in_ready", 32'(in_ready), 1);
      chk("R10 hdr_valid", 32'(hdr_valid), 0);
   endtask

   task automatic t_idle_zero;
      send_byte(8'h00, 0);
      chk("R2 idle zero no stop", 32'(stop_pulse), 0);
      chk("R2 idle zero streaming", 32'(streaming), 0);
      chk("R2 idle zero no header", 32'(hdr_valid), 0);
      chk("R2 idle zero lo", lo_freq, 32'd94500000);
   endtask

   task automatic t_start_tune;
      send_frame(8'h01, 32'd100000, 0);
      chk("R3 tune lo", lo_freq, 32'd200000);
      chk("R7 streaming", 32'(streaming), 1);
      check_header("R7");
      chk("R7 pulse one cycle", 32'(start_pulse), 0);
   endtask

   task automatic t_rate;
      send_frame(8'h02, 32'd250000, 0);
      chk("R4 rate", samp_rate, 32'd250000);
      chk("R4 lo", lo_freq, 32'd500000);
      chk("R8 no start", 32'(start_pulse), 0);
      chk("R8 no header", 32'(hdr_valid), 0);
      send_frame(8'h02, 32'h9000_0000, 0);
      chk("R4 lo wraps", lo_freq, 32'h2000_0000);
      send_frame(8'h02, 32'd250000, 0);
   endtask

   task automatic t_tune_gaps;
      send_frame(8'h01, 32'h0010_0000, 3);
      chk("R1 gaps R3 lo", lo_freq, 32'h0010_0000 + 32'd250000);
      send_frame(8'h01, 32'hFFFF_FFFF, 0);
      chk("R3 wrap", lo_freq, 32'hFFFF_FFFF + 32'd250000);
      send_frame(8'h01, 32'h0000_0000, 0);
      chk("R2 inner zeros are data", lo_freq, 32'd250000);
   endtask

   task automatic t_gain_db;
      send_frame(8'h04, 32'd200, 0);
      chk("R5 gain 20dB", 32'(gain_code), ref_gain(200));
      send_frame(8'h04, 32'd0, 0);
      chk("R5 gain 0dB", 32'(gain_code), 32'd127);
      send_frame(8'h04, 32'd333, 0);
      chk("R5 gain 33.3dB", 32'(gain_code), ref_gain(333));
      send_frame(8'h04, 32'd100000, 0);
      chk("R5 gain clamp", 32'(gain_code), ref_gain(511));
   endtask

   task automatic t_gain_idx;
      send_frame(8'h0D, 32'd7, 0);
      chk("R6 idx 7", 32'(gain_code), ref_gain(125));
      send_frame(8'h0D, 32'd0, 0);
      chk("R6 idx 0", 32'(gain_code), 32'd127);
      send_frame(8'h0D, 32'd28, 0);
      chk("R6 idx 28", 32'(gain_code), ref_gain(496));
      send_frame(8'h0D, 32'd17, 0);
      chk("R6 idx 17", 32'(gain_code), ref_gain(328));
      send_frame(8'h0D, 32'd40, 0);
      chk("R6 idx clamp", 32'(gain_code), ref_gain(496));
   endtask

   task automatic t_unknown;
      logic [31:0] lo0, rate0;
      logic [15:0] g0;
      lo0 = lo_freq; rate0 = samp_rate; g0 = gain_code;
      send_frame(8'h07, 32'h0000_0010, 0);
      chk("R9 lo kept", lo_freq, lo0);
      chk("R9 rate kept", samp_rate, rate0);
      chk("R9 gain kept", 32'(gain_code), 32'(g0));
      send_frame(8'h03, 32'h0001_0000, 0);
      chk("R9 lo kept 2", lo_freq, lo0);
      chk("R9 gain kept 2", 32'(gain_code), 32'(g0));
   endtask

   task automatic t_stop_restart;
      send_byte(8'h00, 0);
      chk("R2 stop pulse", 32'(stop_pulse), 1);
      chk("R2 streaming cleared", 32'(streaming), 0);
      @(negedge clk);
      chk("R2 stop one cycle", 32'(stop_pulse), 0);
      send_frame(8'h09, 32'd1, 0);
      chk("R7 R9 restart streaming", 32'(streaming), 1);
      check_header("R7 restart");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_zero();
      t_start_tune();
      t_rate();
      t_tune_gaps();
      t_gain_db();
      t_gain_idx();
      t_unknown();
      t_stop_restart();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule